// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block turns a programmed brightness value into a pulse-width-modulated drive for a display backlight. It runs from the reference clock. A prescaler divides that clock into step ticks. A step counter then walks through `scale + 1` steps to make one PWM period. The output is high during the leading `level` steps of every period. Two values override the count: a level of zero holds the output low, and a level that reaches the scale holds it high.

The three programmed values are level, scale and prescale. The block copies them into internal shadow copies only when a period begins. Software can therefore write them at any moment without producing a truncated or split pulse. A 2-bit pin-function input decides what reaches the general-purpose pin. When it selects the PWM function, the pin carries the modulated signal. Under any other code, the pin carries a plain GPIO data bit.

Top module: `bl_pwm_top`

## Requirements
- R1: While `rst` is sampled high, the PWM state is cleared. From the edge after any reset edge up to the first edge with `rst` low, a pin set to the PWM function reads 0.
- R2: Take the first edge with `rst` low as the start of period 0. Within each period the output is high for exactly the leading `level` steps and low for the rest. With scale 0x00FF, level 0x0040 and prescale 1, it is high for 64 of 256 cycles (25%).
- R3: One period lasts `max(prescale,1) × (scale + 1)` reference cycles. Each step lasts `max(prescale,1)` cycles.
- R4: A level of 0x0000 holds the output low for the whole period.
- R5: A nonzero level greater than or equal to the scale holds the output high for the whole period.
- R6: A prescale value of 0 behaves the same as a prescale value of 1.
- R7: Changes to the level, scale and prescale inputs take effect only at the next period start. A period that is already running finishes with the values it started with.
- R8: `pin_o` follows the PWM only when `pin_fn_i` is 2'b10. The codes 2'b00, 2'b01 and 2'b11 pass `gpio_val_i` straight to `pin_o` in the same cycle.
- R9: When the scale is 0, each period is a single step. Level 0 then gives a constant low and any nonzero level gives a constant high. The level-zero rule wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | LVL_W (16) | Brightness level |
| scale_i | input | LVL_W (16) | Highest step index; the period has scale+1 steps |
| prediv_i | input | PRE_W (8) | Reference cycles per step (0 is treated as 1) |
| pin_fn_i | input | 2 | Pin function select; 2'b10 selects the PWM |
| gpio_val_i | input | 1 | Plain GPIO data used when the PWM is not selected |
| pin_o | output | 1 | General-purpose pin output |

## Verification
A wrong counter or shadow value shows up at the pin as a high time or period length that differs from the programmed values. A bad step count moves the falling edge within a single step. A bad prescaler or wrap compare moves the next rising edge within one period. A shadow copy that loads in mid-period shows as a changed high time before the period boundary. Every cycle is compared against a timeline model, so any of these faults is reported in the first cycle where the pin differs.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

  // Pin function codes seen on pin_fn_i
  typedef enum logic [1:0] {
    PINF_IN   = 2'b00,
    PINF_OUT  = 2'b01,
    PINF_PWM  = 2'b10,
    PINF_RSVD = 2'b11
  } pin_fn_e;

  // Effective prescale: zero is promoted to one
  function automatic logic [31:0] eff_div(input logic [31:0] pre);
    return (pre == 32'd0) ? 32'd1 : pre;
  endfunction

  // Output level for a given step under given shadow values
  function automatic logic duty_on(input logic [31:0] step,
                                   input logic [31:0] level,
                                   input logic [31:0] scale);
    if (level == 32'd0)       return 1'b0;
    else if (level >= scale)  return 1'b1;
    else                      return (step < level);
  endfunction

endpackage

// File: rtl/bl_pwm_shadow.sv
module bl_pwm_shadow #(
  parameter int LVL_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] scale_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic [LVL_W-1:0] level_q,
  output logic [LVL_W-1:0] scale_q,
  output logic [PRE_W-1:0] pre_q,
  output logic [LVL_W-1:0] level_d,
  output logic [LVL_W-1:0] scale_d,
  output logic             primed
);
  logic [PRE_W-1:0] pre_d;

  assign level_d = load ? level_i : level_q;
  assign scale_d = load ? scale_i : scale_q;
  assign pre_d   = load ? pre_i   : pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      scale_q <= '0;
      pre_q   <= '0;
      primed  <= 1'b0;
    end else begin
      level_q <= level_d;
      scale_q <= scale_d;
      pre_q   <= pre_d;
      primed  <= 1'b1;
    end
  end
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] div,
  output logic             tick,
  output logic [PRE_W-1:0] cnt_o
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  assign last  = (div == '0) ? '0 : div - PRE_W'(1);
  assign tick  = run && (cnt == last);
  assign cnt_o = cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt <= '0;
    else if (run)        cnt <= tick ? '0 : cnt + PRE_W'(1);
  end
endmodule

// File: rtl/bl_pwm_stepper.sv
module bl_pwm_stepper #(
  parameter int LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [LVL_W-1:0] limit,
  output logic [LVL_W-1:0] step_q,
  output logic [LVL_W-1:0] step_d,
  output logic             wrap
);
  assign wrap   = tick && (step_q == limit);
  assign step_d = restart ? '0 : (tick ? step_q + LVL_W'(1) : step_q);

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/bl_pwm_out.sv
module bl_pwm_out #(
  parameter int LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] step_d,
  input  logic [LVL_W-1:0] level_d,
  input  logic [LVL_W-1:0] scale_d,
  output logic             pwm_q
);
  import bl_pwm_pkg::*;

  logic pwm_d;
  assign pwm_d = duty_on(32'(step_d), 32'(level_d), 32'(scale_d));

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_d;
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top #(
  parameter int LVL_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] scale_i,
  input  logic [PRE_W-1:0] prediv_i,
  input  logic [1:0]       pin_fn_i,
  input  logic             gpio_val_i,
  output logic             pin_o
);
  import bl_pwm_pkg::*;

  // Named internal events, observed by the bound checker
  logic             primed;
  logic             boundary;
  logic             tick;
  logic             wrap;
  logic [PRE_W-1:0] pre_cnt;
  logic [LVL_W-1:0] step_q, step_d;
  logic [LVL_W-1:0] sh_level, sh_scale, level_d, scale_d;
  logic [PRE_W-1:0] sh_pre;
  logic             pwm_q;

  assign boundary = !primed || wrap;

  bl_pwm_shadow #(.LVL_W(LVL_W), .PRE_W(PRE_W)) u_shadow (
    .clk(clk), .rst(rst), .load(boundary),
    .level_i(level_i), .scale_i(scale_i), .pre_i(prediv_i),
    .level_q(sh_level), .scale_q(sh_scale), .pre_q(sh_pre),
    .level_d(level_d), .scale_d(scale_d), .primed(primed)
  );

  bl_pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(primed), .restart(boundary),
    .div(sh_pre), .tick(tick), .cnt_o(pre_cnt)
  );

  bl_pwm_stepper #(.LVL_W(LVL_W)) u_step (
    .clk(clk), .rst(rst), .restart(boundary), .tick(tick),
    .limit(sh_scale), .step_q(step_q), .step_d(step_d), .wrap(wrap)
  );

  bl_pwm_out #(.LVL_W(LVL_W)) u_out (
    .clk(clk), .rst(rst), .step_d(step_d),
    .level_d(level_d), .scale_d(scale_d), .pwm_q(pwm_q)
  );

  assign pin_o = (pin_fn_e'(pin_fn_i) == PINF_PWM) ? pwm_q : gpio_val_i;
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int LVL_W = 16,
  parameter int PRE_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             primed,
  input logic             wrap,
  input logic [LVL_W-1:0] step,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [LVL_W-1:0] sh_level,
  input logic [LVL_W-1:0] sh_scale,
  input logic [PRE_W-1:0] sh_pre,
  input logic             pwm_q
);
  import bl_pwm_pkg::*;

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !pwm_q); // R1

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_q) |-> (step == '0)); // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    primed |-> (step <= sh_scale)); // R3

  AST_ZERO_LEVEL_LOW: assert property (@(posedge clk) disable iff (rst)
    (primed && sh_level == '0) |-> !pwm_q); // R4

  AST_FULL_LEVEL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (primed && sh_level != '0 && sh_level >= sh_scale) |-> pwm_q); // R5

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
    primed |-> (32'(pre_cnt) < eff_div(32'(sh_pre)))); // R6

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(primed) && !$past(wrap)) |-> ($stable(sh_level) && $stable(sh_scale) && $stable(sh_pre))); // R7
endmodule

bind bl_pwm_top bl_pwm_chk #(.LVL_W(LVL_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .primed(primed), .wrap(wrap), .step(step_q),
  .pre_cnt(pre_cnt), .sh_level(sh_level), .sh_scale(sh_scale),
  .sh_pre(sh_pre), .pwm_q(pwm_q)
);

// File: tb/sim_bl_pwm_top.sv
module sim_bl_pwm_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;
  localparam int PW = 8;

  typedef struct {
    bit    exp;
    string req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] level = '0;
  logic [LW-1:0] scale = '0;
  logic [PW-1:0] prediv = '0;
  logic [1:0]    fn = 2'b10;
  logic          gval = 1'b0;
  logic          pin;

  int    checks = 0;
  int    errors = 0;
  int    hcount = 0;
  bit    done = 0;
  string cur_req = "R1";
  exp_t  sb[$];

  // timeline model state
  int m_t = 0;
  bit m_pr = 0;
  int mL = 0, mS = 0, mP = 1;
  bit m_out = 0;

  bl_pwm_top #(.LVL_W(LW), .PRE_W(PW)) u0 (
    .clk(clk), .rst(rst), .level_i(level), .scale_i(scale),
    .prediv_i(prediv), .pin_fn_i(fn), .gpio_val_i(gval), .pin_o(pin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of one edge: position in period as a linear time index
  task automatic model_edge();
    int per;
    int stp;
    if (rst) begin
      m_pr = 0;
      m_out = 0;
    end else begin
      per = mP * (mS + 1);
      if (!m_pr || m_t == per - 1) begin
        mL = int'(level);
        mS = int'(scale);
        mP = (prediv == 0) ? 1 : int'(prediv);
        m_t = 0;
        m_pr = 1;
      end else begin
        m_t++;
      end
      stp = m_t / mP;
      m_out = (mL != 0) && ((mL >= mS) || (stp < mL));
    end
  endtask

  // Driver: one expected item per clock edge
  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t it;
      @(posedge clk);
      model_edge();
      it.exp = (fn == 2'b10) ? m_out : gval;
      it.req = cur_req;
      sb.push_back(it);
      @(negedge clk);
      #1;
    end
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if (pin !== it.exp) begin
        errors++;
        $display("FAIL %s: pin_o actual=%0b expected=%0b at %0t", it.req, pin, it.exp, $time);
      end
      if (pin === 1'b1) hcount++;
    end
  end

  task automatic check_count(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: high count actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset holds the pin low in PWM mode
    fn = 2'b10; level = 16'h0040; scale = 16'h00FF; prediv = 8'd1;
    rst = 1'b1;
    cur_req = "R1";
    run_cycles(4);
    rst = 1'b0;

    // R2: 25% duty over one full 256-cycle period
    cur_req = "R2";
    hcount = 0;
    run_cycles(256);
    check_count("R2", hcount, 64);
    run_cycles(300);

    // R7: new values written mid-period apply only at the next start
    cur_req = "R7";
    level = 16'd2; scale = 16'd4; prediv = 8'd3;
    run_cycles(250);

    // R3: period of 3 x 5 cycles, high for 2 steps of 3 cycles
    cur_req = "R3";
    run_cycles(60);

    // R6: prescale zero acts as one
    cur_req = "R6";
    level = 16'd3; scale = 16'd7; prediv = 8'd0;
    run_cycles(64);

    // R4: level zero keeps the output low
    cur_req = "R4";
    level = 16'd0;
    run_cycles(40);

    // R5: level equal to or above the scale keeps it high
    cur_req = "R5";
    level = 16'd7; prediv = 8'd2;
    run_cycles(48);
    level = 16'd9;
    run_cycles(48);

    // R9: single-step periods
    cur_req = "R9";
    scale = 16'd0; level = 16'd0; prediv = 8'd1;
    run_cycles(20);
    level = 16'd1;
    run_cycles(20);

    // R8: other pin functions pass the GPIO value through
    cur_req = "R8";
    level = 16'd1; scale = 16'd3;
    for (int f = 0; f < 4; f++) begin
      if (f != 2) begin
        fn = 2'(f);
        for (int k = 0; k < 6; k++) begin
          gval = k[0];
          run_cycles(1);
        end
      end
    end
    fn = 2'b10;
    run_cycles(12);

    // R1: reset in the middle of a period
    cur_req = "R1";
    level = 16'd2; scale = 16'd5; prediv = 8'd2;
    run_cycles(7);
    rst = 1'b1;
    run_cycles(3);
    rst = 1'b0;
    cur_req = "R2";
    run_cycles(40);

    @(negedge clk);
    finish_run();
  end
endmodule